// File: doc/BRIEF.md
# Framed Serial Character Transmitter

This block turns one character at a time into a framed serial stream. A request on `txStart` while the block is idle captures the data word and the whole line configuration. The block then sends a low start bit, the data bits least significant first, and one or two high stop bits. The line rests high between frames. The character length comes from a 3-bit size code. The stop-bit count, the timing mode and the clock polarity each come from an input of their own. A 12-bit divisor sets the bit rate.

In asynchronous mode each bit lasts (divisor + 1) × 16 system clocks and the shift clock stays low. In synchronous mode each bit lasts (divisor + 1) × 2 system clocks, and the block drives a shift clock with one full cycle per bit. The polarity input chooses on which edge of that clock the data line changes. When a frame finishes, `busy` falls and `done` pulses for one cycle. A new request may be accepted in that same cycle, so frames can be sent back to back with no idle gap.

Top module: `usart_tx`

## Requirements
- R1: After reset, and with `syncMode` at 0, `serOut` is 1 and `busy`, `done`, `cfgErr` and `shiftClk` are all 0. Whenever `busy` is 0, `serOut` is 1.
- R2: A frame is a 0 start bit, then the data bits from bit 0 upward, then the stop bits at 1.
- R3: Size code 0, 1, 2 and 3 send 5, 6, 7 and 8 data bits. Code 7 sends 9 data bits. Data bits above the selected length are never sent.
- R4: Codes 4, 5 and 6 are reserved. Each of them sends 8 data bits and sets `cfgErr` to 1 from the cycle after the request is accepted. `cfgErr` is updated only when a request is accepted, so an accepted valid code clears it.
- R5: `stopTwo` at 0 appends one stop bit. At 1 it appends two.
- R6: In asynchronous mode (`syncMode` = 0) every bit lasts (`baudDiv` + 1) × 16 clocks and `shiftClk` stays 0.
- R7: In synchronous mode every bit lasts (`baudDiv` + 1) × 2 clocks. `shiftClk` makes its launch transition at the start of each bit, when `serOut` changes, and returns at mid-bit. The launch transition is rising for `clkPol` 0 and falling for `clkPol` 1. While the block is idle in synchronous mode, `shiftClk` rests at `clkPol`.
- R8: An accepted request raises `busy` in the next cycle, with the start bit on `serOut`. A `txStart` while `busy` is 1 has no effect.
- R9: `done` is 1 for exactly one cycle: the first cycle after the last stop bit ends. In that cycle `busy` is already 0, and a request present in that cycle is accepted.
- R10: Data and configuration are captured when the request is accepted. Changing the inputs during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txStart | input | 1 | Request to send one character |
| txData | input | 9 | Character to send; the bits above the selected length are unused |
| sizeCode | input | 3 | Character length code |
| stopTwo | input | 1 | 0: one stop bit, 1: two stop bits |
| syncMode | input | 1 | 0: asynchronous, 1: synchronous with shift clock |
| clkPol | input | 1 | Shift clock polarity (synchronous mode only) |
| baudDiv | input | 12 | Bit rate divisor |
| serOut | output | 1 | Serial data line |
| shiftClk | output | 1 | Shift clock in synchronous mode |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse after the final stop bit |
| cfgErr | output | 1 | The last accepted request used a reserved size code |

## Verification
The end of one frame and the acceptance of the next can fall in the same cycle. In that cycle `done` is high, `busy` is low, and a waiting `txStart` must be taken. The driver always presents its next request as soon as it sees `busy` low, so most frames follow the one before with no gap. The scoreboard then requires, for every frame, a `done` pulse in the cycle it predicts, followed by the next frame starting exactly one cycle later, bit for bit. A start strobe with altered inputs is also injected in the middle of a frame. That strobe must leave the frame length and contents unchanged.

// File: rtl/usart_tx_pkg.sv
package usart_tx_pkg;

  localparam int MAX_BITS = 9;
  localparam int BITS_W   = $clog2(MAX_BITS + 1);

  typedef enum logic [1:0] {
    LINE_IDLE,
    LINE_START,
    LINE_DATA,
    LINE_STOP
  } lineSel_e;

  typedef struct packed {
    logic     load;
    logic     shift;
    lineSel_e lineSel;
  } dpCtrl_t;

  function automatic logic codeReserved(input logic [2:0] code);
    return (code == 3'd4) || (code == 3'd5) || (code == 3'd6);
  endfunction

  function automatic logic [BITS_W-1:0] codeToBits(input logic [2:0] code);
    logic [BITS_W-1:0] n;
    case (code)
      3'd0:    n = BITS_W'(5);
      3'd1:    n = BITS_W'(6);
      3'd2:    n = BITS_W'(7);
      3'd7:    n = BITS_W'(9);
      default: n = BITS_W'(8);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/usart_tx_ctrl.sv
module usart_tx_ctrl
  import usart_tx_pkg::*;
#(
  parameter int DIV_W      = 12,
  parameter int OVERSAMPLE = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txStart,
  input  logic [2:0]       sizeCode,
  input  logic             stopTwo,
  input  logic             syncMode,
  input  logic             clkPol,
  input  logic [DIV_W-1:0] baudDiv,
  output logic             busy,
  output logic             done,
  output logic             shiftClk,
  output logic             cfgErr,
  output dpCtrl_t          dpCtl
);

  localparam int ASYNC_SH = $clog2(OVERSAMPLE / 2);
  localparam int HALF_W   = DIV_W + ASYNC_SH + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} state_e;

  state_e              state;
  logic [HALF_W-1:0]   halfCnt;
  logic [HALF_W-1:0]   halfLenQ;
  logic                secondHalf;
  logic [BITS_W-1:0]   bitsLeft;
  logic [BITS_W-1:0]   nDataQ;
  logic                stopsLeft;
  logic                twoStopQ;
  logic                syncQ;
  logic                polQ;

  logic [HALF_W-1:0]   divPlusOne;
  logic [HALF_W-1:0]   halfLenIn;
  logic                accept;
  logic                halfEnd;
  logic                bitEnd;

  assign divPlusOne = {{(HALF_W - DIV_W){1'b0}}, baudDiv} + HALF_W'(1);
  assign halfLenIn  = syncMode ? divPlusOne : (divPlusOne << ASYNC_SH);

  assign busy    = (state != ST_IDLE);
  assign accept  = txStart && !busy;
  assign halfEnd = (halfCnt == '0);
  assign bitEnd  = busy && secondHalf && halfEnd;

  // launch transition in the first half of each bit, return at mid-bit
  assign shiftClk = busy ? (polQ ^ (syncQ & ~secondHalf)) : (syncMode & clkPol);

  always_comb begin
    dpCtl.load  = accept;
    dpCtl.shift = bitEnd && (state == ST_DATA);
    case (state)
      ST_START: dpCtl.lineSel = LINE_START;
      ST_DATA:  dpCtl.lineSel = LINE_DATA;
      ST_STOP:  dpCtl.lineSel = LINE_STOP;
      default:  dpCtl.lineSel = LINE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      halfCnt    <= '0;
      halfLenQ   <= '0;
      secondHalf <= 1'b0;
      bitsLeft   <= '0;
      nDataQ     <= '0;
      stopsLeft  <= 1'b0;
      twoStopQ   <= 1'b0;
      syncQ      <= 1'b0;
      polQ       <= 1'b0;
      cfgErr     <= 1'b0;
      done       <= 1'b0;
    end else if (accept) begin
      state      <= ST_START;
      halfLenQ   <= halfLenIn;
      halfCnt    <= halfLenIn - HALF_W'(1);
      secondHalf <= 1'b0;
      nDataQ     <= codeToBits(sizeCode);
      twoStopQ   <= stopTwo;
      syncQ      <= syncMode;
      polQ       <= syncMode & clkPol;
      cfgErr     <= codeReserved(sizeCode);
      done       <= 1'b0;
    end else if (busy) begin
      done <= 1'b0;
      if (halfEnd) begin
        halfCnt    <= halfLenQ - HALF_W'(1);
        secondHalf <= ~secondHalf;
      end else begin
        halfCnt <= halfCnt - HALF_W'(1);
      end
      if (bitEnd) begin
        case (state)
          ST_START: begin
            state    <= ST_DATA;
            bitsLeft <= nDataQ - BITS_W'(1);
          end
          ST_DATA: begin
            if (bitsLeft == '0) begin
              state     <= ST_STOP;
              stopsLeft <= twoStopQ;
            end else begin
              bitsLeft <= bitsLeft - BITS_W'(1);
            end
          end
          ST_STOP: begin
            if (!stopsLeft) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              stopsLeft <= 1'b0;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end else begin
      done <= 1'b0;
    end
  end

  // R9: the end-of-frame pulse never lasts two cycles
  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: done only follows a cycle in which a frame was running
  a_r9_done_after_frame: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R8: a frame only begins after a request
  a_r8_busy_needs_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(txStart));

endmodule

// File: rtl/usart_tx_dp.sv
module usart_tx_dp
  import usart_tx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtl,
  input  logic [DATA_W-1:0] txData,
  output logic              serOut
);

  logic [DATA_W-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (dpCtl.load) begin
      shReg <= txData;
    end else if (dpCtl.shift) begin
      shReg <= {1'b0, shReg[DATA_W-1:1]};
    end
  end

  always_comb begin
    case (dpCtl.lineSel)
      LINE_START: serOut = 1'b0;
      LINE_DATA:  serOut = shReg[0];
      default:    serOut = 1'b1;
    endcase
  end

  // R2: shifting only happens while data bits are on the line
  a_r2_shift_in_data: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.shift |-> (dpCtl.lineSel == LINE_DATA));

endmodule

// File: rtl/usart_tx.sv
module usart_tx
  import usart_tx_pkg::*;
#(
  parameter int DIV_W      = 12,
  parameter int OVERSAMPLE = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                txStart,
  input  logic [MAX_BITS-1:0] txData,
  input  logic [2:0]          sizeCode,
  input  logic                stopTwo,
  input  logic                syncMode,
  input  logic                clkPol,
  input  logic [DIV_W-1:0]    baudDiv,
  output logic                serOut,
  output logic                shiftClk,
  output logic                busy,
  output logic                done,
  output logic                cfgErr
);

  dpCtrl_t dpCtl;

  usart_tx_ctrl #(
    .DIV_W      (DIV_W),
    .OVERSAMPLE (OVERSAMPLE)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .txStart  (txStart),
    .sizeCode (sizeCode),
    .stopTwo  (stopTwo),
    .syncMode (syncMode),
    .clkPol   (clkPol),
    .baudDiv  (baudDiv),
    .busy     (busy),
    .done     (done),
    .shiftClk (shiftClk),
    .cfgErr   (cfgErr),
    .dpCtl    (dpCtl)
  );

  usart_tx_dp #(
    .DATA_W (MAX_BITS)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .dpCtl  (dpCtl),
    .txData (txData),
    .serOut (serOut)
  );

  // R1: the line rests high whenever no frame runs
  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> serOut);

  // R4: the error flag moves only when a request is taken
  a_r4_err_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgErr) |-> $rose(busy));

endmodule

// File: tb/usart_tx_tb.sv
module usart_tx_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic       txStart;
  logic [8:0] txData;
  logic [2:0] sizeCode;
  logic       stopTwo;
  logic       syncMode;
  logic       clkPol;
  logic [11:0] baudDiv;
  logic       serOut;
  logic       shiftClk;
  logic       busy;
  logic       done;
  logic       cfgErr;

  always #2 clk = ~clk;

  usart_tx u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .txStart  (txStart),
    .txData   (txData),
    .sizeCode (sizeCode),
    .stopTwo  (stopTwo),
    .syncMode (syncMode),
    .clkPol   (clkPol),
    .baudDiv  (baudDiv),
    .serOut   (serOut),
    .shiftClk (shiftClk),
    .busy     (busy),
    .done     (done),
    .cfgErr   (cfgErr)
  );

  typedef struct {
    logic [11:0] bits;
    int          nBits;
    int          half;
    bit          clkFirst;
    bit          clkSecond;
    string       tag;
  } item_t;

  item_t expQ[$];
  int total = 0;
  int bad   = 0;
  int sent  = 0;
  int seen  = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic sendFrame(input logic [8:0] data, input logic [2:0] code,
                           input bit two, input bit sync, input bit pol,
                           input int div, input string tag);
    item_t it;
    int    nd;
    bit    rsv;
    while (busy === 1'b1) @(negedge clk);
    rsv = (code == 3'd4) || (code == 3'd5) || (code == 3'd6);
    nd  = (code == 3'd7) ? 9 : (code <= 3'd3) ? 5 + int'(code) : 8;
    it.bits = '1;
    it.bits[0] = 1'b0;
    for (int i = 0; i < nd; i++) it.bits[1 + i] = data[i];
    it.nBits     = 2 + nd + int'(two);
    it.half      = sync ? div + 1 : (div + 1) * 8;
    it.clkFirst  = sync ? ~pol : 1'b0;
    it.clkSecond = sync ? pol : 1'b0;
    it.tag       = tag;
    expQ.push_back(it);
    sent++;
    txData   = data;
    sizeCode = code;
    stopTwo  = two;
    syncMode = sync;
    clkPol   = pol;
    baudDiv  = 12'(div);
    txStart  = 1'b1;
    @(negedge clk);
    txStart = 1'b0;
    check(busy === 1'b1 && serOut === 1'b0, "R8", "busy/start bit after request",
          {busy, serOut}, 2'b10);
    check(cfgErr === rsv, "R4", "cfgErr after accept", cfgErr, rsv);
  endtask

  // scoreboard monitor
  initial begin : monitor
    bit    prevBusy;
    bit    doneSeen;
    item_t it;
    logic [11:0] got;
    bit    clkOk;
    prevBusy = 1'b0;
    doneSeen = 1'b0;
    wait (rstN === 1'b1);
    forever begin
      @(negedge clk);
      if (doneSeen) begin
        check(done === 1'b0, "R9", "done width", done, 1'b0);
        doneSeen = 1'b0;
      end
      if (busy === 1'b1 && !prevBusy) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R8", "unexpected frame", 1, 0);
          prevBusy = 1'b1;
        end else begin
          it = expQ.pop_front();
          seen++;
          got = '1;
          clkOk = 1'b1;
          for (int k = 0; k < it.nBits; k++) begin
            got[k] = serOut;
            if (shiftClk !== it.clkFirst) clkOk = 1'b0;
            repeat (it.half) @(negedge clk);
            if (shiftClk !== it.clkSecond) clkOk = 1'b0;
            repeat (it.half) @(negedge clk);
          end
          check(got === it.bits, it.tag, "frame bits", got, it.bits);
          check(clkOk, it.tag, "shift clock shape", clkOk, 1'b1);
          check(done === 1'b1 && busy === 1'b0, "R9", "done at frame end",
                {done, busy}, 2'b10);
          doneSeen = 1'b1;
          prevBusy = 1'b0;
        end
      end else begin
        prevBusy = busy;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", seen, sent);
    summary();
    $finish;
  end

  initial begin : stimulus
    rstN = 1'b0; txStart = 1'b0; txData = '0; sizeCode = '0; stopTwo = 1'b0;
    syncMode = 1'b0; clkPol = 1'b0; baudDiv = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    check(serOut === 1'b1 && busy === 1'b0 && done === 1'b0 && cfgErr === 1'b0 &&
          shiftClk === 1'b0, "R1", "reset state",
          {serOut, busy, done, cfgErr, shiftClk}, 5'b10000);
    // R7: idle shift clock level follows polarity in synchronous mode
    syncMode = 1'b1; clkPol = 1'b1;
    @(negedge clk);
    check(shiftClk === 1'b1, "R7", "idle shiftClk pol1", shiftClk, 1'b1);
    syncMode = 1'b0; clkPol = 1'b0;
    @(negedge clk);

    sendFrame(9'h1F5, 3'd0, 1'b0, 1'b0, 1'b0, 0, "R3/R2 5-bit");
    sendFrame(9'h02A, 3'd1, 1'b1, 1'b0, 1'b0, 0, "R5 6-bit two stops");
    sendFrame(9'h055, 3'd2, 1'b0, 1'b0, 1'b0, 1, "R6 7-bit div1");
    sendFrame(9'h0C3, 3'd3, 1'b1, 1'b0, 1'b0, 0, "R5/R3 8-bit");
    sendFrame(9'h1A5, 3'd7, 1'b0, 1'b0, 1'b0, 0, "R3 9-bit");
    sendFrame(9'h13C, 3'd5, 1'b0, 1'b0, 1'b0, 0, "R4 reserved code");
    sendFrame(9'h081, 3'd3, 1'b0, 1'b0, 1'b0, 0, "R4 valid after reserved");
    sendFrame(9'h0B2, 3'd3, 1'b0, 1'b1, 1'b0, 0, "R7 sync pol0");
    sendFrame(9'h019, 3'd1, 1'b1, 1'b1, 1'b1, 3, "R7 sync pol1");

    // R8/R10: a mid-frame request with altered inputs must change nothing
    sendFrame(9'h0E7, 3'd3, 1'b0, 1'b0, 1'b0, 0, "R10 capture");
    repeat (40) @(negedge clk);
    txData = 9'h000; sizeCode = 3'd7; stopTwo = 1'b1; baudDiv = 12'd5;
    txStart = 1'b1;
    @(negedge clk);
    txStart = 1'b0;
    check(busy === 1'b1, "R8", "busy held during ignored request", busy, 1'b1);

    // idle gap then another frame
    while (busy === 1'b1) @(negedge clk);
    repeat (7) @(negedge clk);
    check(serOut === 1'b1 && busy === 1'b0, "R1", "line high when idle",
          {serOut, busy}, 2'b10);
    sendFrame(9'h16E, 3'd7, 1'b1, 1'b0, 1'b0, 0, "R2 after gap");

    while (expQ.size() != 0 || busy === 1'b1) @(negedge clk);
    repeat (3) @(negedge clk);
    check(seen == sent, "R8", "frame count", seen, sent);
    summary();
    $finish;
  end

endmodule